// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Thresholds

This block is a one-direction first-in first-out buffer that joins a producer on one clock and a consumer on an unrelated clock. It holds 18-bit words and its depth is 256 or 512 words, chosen by a parameter. The producer writes with an active-low enable. The consumer reads with an active-low enable and receives each word in a registered output one read-clock edge later.

Four active-low status outputs tell each side how much room or data is left. Full and almost-full are produced in the write-clock domain. Empty and almost-empty are produced in the read-clock domain. Occupancy crosses between the domains as Gray-coded pointers through two-flop synchronisers. A flag that clears because of the other side's activity may therefore clear a few cycles late, but a flag never sets late. The two almost thresholds come from offset registers that are loaded on the write clock and both return to 8 on reset.

Top module: `dcfifo_thresh`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, and each stored word is 18 bits.
- R2: A read is accepted at a read-clock edge where `rd_n` is 0 and `empty_n` is 1. The word from the head of the queue appears on `rd_data` after that edge and holds until the next accepted read.
- R3: In the read domain, `empty_n` is 0 exactly when the queue holds 0 words. `aempty_n` is 0 exactly when the word count is less than or equal to the empty offset n.
- R4: In the write domain, `full_n` is 0 exactly when the queue holds DEPTH words. `afull_n` is 0 exactly when the word count is greater than DEPTH minus the full offset m.
- R5: A write with `full_n` at 0 stores nothing and does not move the write pointer. A read with `empty_n` at 0 leaves `rd_data` and the read pointer unchanged.
- R6: While `rst_n` is 0, both pointers return to the first location, `empty_n` and `aempty_n` become 0, `full_n` and `afull_n` become 1, and both offsets return to 8.
- R7: At a write-clock edge where `ld_n` is 0, `ld_val` is stored as the empty offset n when `ld_sel` is 0, or as the full offset m when `ld_sel` is 1.
- R8: Offsets are 9 bits wide. When DEPTH is 256, bit 8 of a loaded offset is stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Reset, active low, sampled by both clocks |
| wr_n | input | 1 | Write enable, active low |
| wr_data | input | 18 | Word to store |
| full_n | output | 1 | Full flag, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |
| ld_n | input | 1 | Offset load strobe, active low, write clock |
| ld_sel | input | 1 | 0 selects the empty offset, 1 selects the full offset |
| ld_val | input | 9 | Offset value to load |
| rd_n | input | 1 | Read enable, active low |
| rd_data | output | 18 | Registered read word |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
Read data is due one read-clock edge after an accepted read, so the bench compares `rd_data` at the falling edge that follows that rising edge. Full and almost-full reflect a write at the next write-clock edge. Flags that depend on the opposite side settle within about four edges of their own clock, through one pointer register, two synchroniser stages and the flag register. Offsets reach the read side over the same synchroniser path. For this reason, every flag check comes only after ten edges of both clocks with no activity, and the flags are then compared with an occupancy model kept in the bench.

// File: rtl/fifo2c_pkg.sv
package fifo2c_pkg;

  typedef enum logic {
    SEL_EMPTY_OFF = 1'b0,
    SEL_FULL_OFF  = 1'b1
  } off_sel_e;

  function automatic logic [15:0] b2g(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] g2b(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/fifo2c_sync.sv
module fifo2c_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) st[i] <= RST_VAL;
        else        st[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) st[i] <= RST_VAL;
        else        st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/fifo2c_ram.sv
module fifo2c_ram #(
  parameter int DW = 18,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo2c_wside.sv
module fifo2c_wside
  import fifo2c_pkg::*;
#(
  parameter int AW = 9,
  parameter int OW = 9,
  parameter int OFF_DEF = 8
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          ld_n,
  input  logic          ld_sel,
  input  logic [OW-1:0] ld_val,
  input  logic [AW:0]   rgray_s,
  output logic          full_n,
  output logic          afull_n,
  output logic          wr_ok,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic [OW-1:0] ae_off
);
  localparam int PW = AW + 1;
  localparam logic [PW:0]   DEPTH_X  = (PW+1)'(1) << AW;
  localparam logic [OW-1:0] OFF_MASK = OW'((1 << AW) - 1);
  localparam logic [OW-1:0] OFF_RST  = OW'(OFF_DEF);

  logic [OW-1:0] af_off;
  logic [PW-1:0] wbin_nx, rbin_s;
  logic [PW:0]   cnt_nx, af_thr;

  always_comb begin
    wr_ok   = !wr_n && full_n;
    wbin_nx = wbin + PW'(wr_ok);
    rbin_s  = PW'(g2b(16'(rgray_s)));
    cnt_nx  = {1'b0, wbin_nx - rbin_s};
    af_thr  = DEPTH_X - (PW+1)'(af_off);
  end

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
      ae_off  <= OFF_RST;
      af_off  <= OFF_RST;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= PW'(b2g(16'(wbin_nx)));
      full_n  <= (cnt_nx != DEPTH_X);
      afull_n <= !(cnt_nx > af_thr);
      if (!ld_n) begin
        if (ld_sel == SEL_FULL_OFF) af_off <= ld_val & OFF_MASK;
        else                        ae_off <= ld_val & OFF_MASK;
      end
    end
  end
endmodule

// File: rtl/fifo2c_rside.sv
module fifo2c_rside
  import fifo2c_pkg::*;
#(
  parameter int AW = 9,
  parameter int OW = 9
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_n,
  input  logic [AW:0]   wgray_s,
  input  logic [OW-1:0] ae_off_s,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          rd_ok,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin_nx, wbin_s, cnt_nx;

  always_comb begin
    rd_ok   = !rd_n && empty_n;
    rbin_nx = rbin + PW'(rd_ok);
    wbin_s  = PW'(g2b(16'(wgray_s)));
    cnt_nx  = wbin_s - rbin_nx;
  end

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= PW'(b2g(16'(rbin_nx)));
      empty_n  <= (cnt_nx != '0);
      aempty_n <= (16'(cnt_nx) > 16'(ae_off_s));
    end
  end
endmodule

// File: rtl/dcfifo_thresh.sv
module dcfifo_thresh #(
  parameter int DW = 18,
  parameter int DEPTH = 512,
  parameter int OW = 9,
  parameter int OFF_DEF = 8
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic [DW-1:0] wr_data,
  output logic          full_n,
  output logic          afull_n,
  input  logic          ld_n,
  input  logic          ld_sel,
  input  logic [OW-1:0] ld_val,
  input  logic          rd_n,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          w_ok, r_ok;
  logic [PW-1:0] w_bin, w_gray, r_bin, r_gray, w_gray_s, r_gray_s;
  logic [OW-1:0] ae_off, ae_off_s;

  fifo2c_wside #(.AW(AW), .OW(OW), .OFF_DEF(OFF_DEF)) u_wside (
    .wclk(wclk), .rst_n(rst_n), .wr_n(wr_n), .ld_n(ld_n), .ld_sel(ld_sel),
    .ld_val(ld_val), .rgray_s(r_gray_s), .full_n(full_n), .afull_n(afull_n),
    .wr_ok(w_ok), .wbin(w_bin), .wgray(w_gray), .ae_off(ae_off)
  );

  fifo2c_sync #(.W(PW), .STAGES(2), .RST_VAL('0)) u_sync_r2w (
    .clk(wclk), .rst_n(rst_n), .d(r_gray), .q(r_gray_s)
  );

  fifo2c_sync #(.W(PW), .STAGES(2), .RST_VAL('0)) u_sync_w2r (
    .clk(rclk), .rst_n(rst_n), .d(w_gray), .q(w_gray_s)
  );

  fifo2c_sync #(.W(OW), .STAGES(2), .RST_VAL(OW'(OFF_DEF))) u_sync_off (
    .clk(rclk), .rst_n(rst_n), .d(ae_off), .q(ae_off_s)
  );

  fifo2c_rside #(.AW(AW), .OW(OW)) u_rside (
    .rclk(rclk), .rst_n(rst_n), .rd_n(rd_n), .wgray_s(w_gray_s),
    .ae_off_s(ae_off_s), .empty_n(empty_n), .aempty_n(aempty_n),
    .rd_ok(r_ok), .rbin(r_bin), .rgray(r_gray)
  );

  fifo2c_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(w_ok), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
    .rclk(rclk), .re(r_ok), .raddr(r_bin[AW-1:0]), .rdata(rd_data)
  );
endmodule

// File: rtl/dcfifo_thresh_chk.sv
module dcfifo_thresh_chk #(
  parameter int PW = 10
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wr_n,
  input logic          rd_n,
  input logic          full_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr
);
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
    (rst_n && !wr_n && !full_n) |=> $stable(wptr)); // R5

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
    (rst_n && !rd_n && !empty_n) |=> $stable(rptr)); // R5

  AST_WPTR_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
    (rst_n && !wr_n && full_n) |=> (wptr == PW'($past(wptr) + 1'b1))); // R1

  AST_EMPTY_IMPLIES_AE: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n); // R3
endmodule

bind dcfifo_thresh dcfifo_thresh_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
  .full_n(full_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .wptr(w_bin), .rptr(r_bin)
);

// File: tb/dcfifo_thresh_tb.sv
`timescale 1ns/1ps
module dcfifo_thresh_tb;
  localparam int D = 512;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_n = 1, ld_n = 1, ld_sel = 0, rd_n = 1;
  logic [17:0] wr_data = '0;
  logic [8:0]  ld_val = '0;
  logic [17:0] rd_data;
  logic full_n, afull_n, empty_n, aempty_n;

  logic b_wr_n = 1, b_ld_n = 1;
  logic [17:0] b_wdata = '0;
  logic [8:0]  b_ld_val = '0;
  logic [17:0] b_rd_data;
  logic b_full_n, b_afull_n, b_empty_n, b_aempty_n;

  always #10 wclk = ~wclk;
  always #15 rclk = ~rclk;

  dcfifo_thresh u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_n(wr_n), .wr_data(wr_data),
    .full_n(full_n), .afull_n(afull_n), .ld_n(ld_n), .ld_sel(ld_sel),
    .ld_val(ld_val), .rd_n(rd_n), .rd_data(rd_data), .empty_n(empty_n),
    .aempty_n(aempty_n)
  );

  dcfifo_thresh #(.DEPTH(256)) u_dut256 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_n(b_wr_n), .wr_data(b_wdata),
    .full_n(b_full_n), .afull_n(b_afull_n), .ld_n(b_ld_n), .ld_sel(1'b0),
    .ld_val(b_ld_val), .rd_n(1'b1), .rd_data(b_rd_data), .empty_n(b_empty_n),
    .aempty_n(b_aempty_n)
  );

  int nchk = 0, nfail = 0;
  logic [17:0] mq [0:2047];
  int head = 0, tail = 0;
  int n_off = 8, m_off = 8;
  logic [17:0] wseq = 18'h100;
  logic [17:0] last_word = '0;

  localparam int NV = 13;
  localparam int VW [NV] = '{1, 7, 1, 494, 1, 1, 6, 1, 3, 0, 0, 0, 0};
  localparam int VR [NV] = '{0, 0, 0, 0,   0, 0, 0, 0, 0, 1, 506, 5, 2};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(posedge wclk);
    repeat (10) @(posedge rclk);
    @(negedge rclk);
  endtask

  task automatic check_flags();
    int c;
    c = tail - head;
    chk("R3", 32'(empty_n),  32'(c != 0),          $sformatf("empty_n at %0d words", c));
    chk("R3", 32'(aempty_n), 32'(c > n_off),       $sformatf("aempty_n at %0d words n=%0d", c, n_off));
    chk("R4", 32'(full_n),   32'(c != D),          $sformatf("full_n at %0d words", c));
    chk("R4", 32'(afull_n),  32'(!(c > D - m_off)), $sformatf("afull_n at %0d words m=%0d", c, m_off));
  endtask

  task automatic do_writes(int n);
    logic acc;
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_n = 0;
      wr_data = wseq;
      acc = full_n;
      @(posedge wclk);
      if (acc) begin
        mq[tail % 2048] = wseq;
        tail++;
      end
      wseq = wseq + 18'h3;
    end
    @(negedge wclk);
    wr_n = 1;
  endtask

  task automatic do_reads(int n);
    logic acc_prev;
    logic [17:0] exp_prev;
    acc_prev = 0;
    exp_prev = '0;
    for (int i = 0; i <= n; i++) begin
      @(negedge rclk);
      if (acc_prev) begin
        chk("R2", 32'(rd_data), 32'(exp_prev), "read word (R1 order)");
        last_word = exp_prev;
      end
      acc_prev = 0;
      if (i < n) begin
        rd_n = 0;
        if (empty_n) begin
          acc_prev = 1;
          exp_prev = mq[head % 2048];
          head++;
        end
      end else begin
        rd_n = 1;
      end
    end
  endtask

  task automatic load_off(logic sel, logic [8:0] v);
    @(negedge wclk);
    ld_n = 0; ld_sel = sel; ld_val = v;
    @(negedge wclk);
    ld_n = 1;
    if (sel) m_off = int'(v); else n_off = int'(v);
  endtask

  task automatic do_reset();
    @(negedge wclk);
    rst_n = 0;
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    rst_n = 1;
    head = 0; tail = 0; n_off = 8; m_off = 8;
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    rst_n = 1;
    settle();
    // R6: reset state
    chk("R6", 32'(empty_n), 0, "empty_n after reset");
    chk("R6", 32'(aempty_n), 0, "aempty_n after reset");
    chk("R6", 32'(full_n), 1, "full_n after reset");
    chk("R6", 32'(afull_n), 1, "afull_n after reset");

    // vector table through every flag boundary with default offsets
    for (int v = 0; v < NV; v++) begin
      if (VW[v] > 0) do_writes(VW[v]);
      if (VR[v] > 0) do_reads(VR[v]);
      settle();
      check_flags();
    end
    // R5: read while empty leaves output unchanged
    chk("R5", 32'(rd_data), 32'(last_word), "rd_data after blocked read");

    // R7: program offsets, check new thresholds
    load_off(1'b0, 9'd20);
    load_off(1'b1, 9'd100);
    do_writes(20);
    settle();
    check_flags(); // R7 aempty low at n=20
    do_writes(1);
    settle();
    check_flags(); // R7 aempty high at 21
    do_writes(391);
    settle();
    check_flags(); // R7 afull high at 412
    do_writes(1);
    settle();
    check_flags(); // R7 afull low at 413

    // R6: reset mid-run, offsets back to default
    do_reset();
    settle();
    chk("R6", 32'(empty_n), 0, "empty_n after mid-run reset");
    chk("R6", 32'(full_n), 1, "full_n after mid-run reset");
    chk("R6", 32'(afull_n), 1, "afull_n after mid-run reset");
    do_writes(9);
    settle();
    chk("R6", 32'(aempty_n), 1, "aempty_n at 9 words with default offset 8");
    do_reads(9);
    settle();
    check_flags();

    // R8: depth 256, bit 8 of offset discarded
    for (int i = 0; i < 6; i++) begin
      @(negedge wclk);
      b_wr_n = 0;
      b_wdata = 18'(i);
    end
    @(negedge wclk);
    b_wr_n = 1;
    settle();
    chk("R8", 32'(b_aempty_n), 0, "depth256 aempty_n at 6 words default n=8");
    @(negedge wclk);
    b_ld_n = 0; b_ld_val = 9'h105;
    @(negedge wclk);
    b_ld_n = 1;
    settle();
    chk("R8", 32'(b_aempty_n), 1, "depth256 aempty_n at 6 words after loading 0x105");
    chk("R8", 32'(b_empty_n), 1, "depth256 empty_n at 6 words");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule